// File: doc/BRIEF.md
# Microprogram Sequencer with Return Register

This block is the control half of a small microprogrammed processor. It holds a fixed control store of 128 words of 20 bits, a 7-bit control address register that points at the word now in effect, and a one-deep return register for microsubroutines. Each clock the word addressed by the control address register is decoded into three groups of one-hot micro-operation strobes, which drive an external datapath. Next-address logic chooses the following address from the word's branch and condition fields, the status inputs, and the opcode bits of the data register.

The sequencer has no data stream. Every pin is a plain level signal, with no valid/ready handshake and no back-pressure. The status inputs and the opcode are sampled at the rising clock edge that moves the control address register. The strobes are a combinational decode of the current word. They therefore change in the same cycle the control address register changes.

Each word is laid out, from the most significant bit down, as three 3-bit micro-operation fields, a 2-bit condition select, a 2-bit branch type and a 7-bit target address. The store holds:
- a three-word fetch routine at address 64;
- routines for opcodes 0 to 4 at addresses 4 times the opcode;
- an indirect-address subroutine at 67.

All other words read as zero.

Top module: `useq_ctrl`

## Requirements
- R1: Reset (rst_n low, asynchronous) sets the control address to 64 and the return register to 0. Both hold those values while reset stays low.
- R2: Each micro-operation field drives its own 8-bit strobe output: bits 19:17 drive f1_stb, bits 16:14 drive f2_stb and bits 13:11 drive f3_stb. Code k raises strobe bit k.
- R3: Every strobe output is one-hot in every cycle, and field code 0 raises bit 0, which means no operation.
- R4: Branch type 00 (bits 8:7) loads the target address (bits 6:0) when the tested bit is 1. Otherwise it loads the current address plus 1.
- R5: Branch type 01 loads the target address and stores current address plus 1 in the return register when the tested bit is 1. Otherwise it loads current address plus 1 and leaves the return register unchanged.
- R6: Branch type 10 loads the return register into the control address, whatever the tested bit, and leaves the return register unchanged.
- R7: Branch type 11 loads {0, dr_opcode[3:0], 0, 0}, whatever the tested bit. Opcode k therefore starts at address 4k.
- R8: The condition field (bits 10:9) picks the tested bit: 00 is constant 1, 01 is dr_ind, 10 is ac_sign and 11 is ac_zero.
- R9: The fetch routine behaves as follows:
  - Address 64 raises f1 code 6 and jumps to 65.
  - Address 65 raises f2 code 4 and f3 code 5, and jumps to 66.
  - Address 66 raises f1 code 5 and maps the opcode.
- R10: The opcode routines behave as follows; every other word reads as zero (no operation, unconditional jump to 0):
  - Opcode 0 calls 67 when dr_ind is set, then raises f2 code 4, then f1 code 1.
  - Opcode 1 skips to 6 when ac_sign is set, then calls 67 when dr_ind is set, then raises f3 code 6. When ac_sign is clear it returns from 5.
  - Opcode 2 calls 67 when dr_ind is set, then raises f2 code 5, then f1 code 7.
  - Opcode 3 calls 67 when dr_ind is set, then raises f2 code 4, then f1 code 4 together with f2 code 5, then f1 code 7.
  - Opcode 4 goes to 18 (f3 code 5) when ac_zero is set, and to 17 (f1 code 3) when it is clear.
  - Address 67 raises f2 code 4. Address 68 raises f1 code 5 and returns.
  - The last word of each routine jumps back to 64.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| dr_opcode | input | 4 | Opcode bits of the data register, used by the map branch |
| dr_ind | input | 1 | Indirect-address bit of the data register |
| ac_sign | input | 1 | Sign bit of the accumulator |
| ac_zero | input | 1 | High when the accumulator is zero |
| car | output | 7 | Current control address |
| sbr | output | 7 | Return register for microsubroutines |
| f1_stb | output | 8 | One-hot decode of the first micro-operation field |
| f2_stb | output | 8 | One-hot decode of the second micro-operation field |
| f3_stb | output | 8 | One-hot decode of the third micro-operation field |

## Verification
The sequencer is walked through every stored routine, once per opcode value 0 to 4. Each status input is set both ways at the branch that tests it, which separates taken from fall-through on jumps and calls. A call followed by a return checks that the saved address is the one after the call. A call that is not taken checks that the return register keeps its earlier value. During map steps the status inputs are set to values that a wrongly conditioned map would react to. Opcode 15 lands on an unloaded word, which shows that all four opcode bits reach the address and that empty words decode as zero. A reset in the middle of a run checks that both registers return to their start values.

// File: rtl/useq_pkg.sv
package useq_pkg;

  localparam int FW  = 3;
  localparam int CDW = 2;
  localparam int BRW = 2;
  localparam int AW  = 7;
  localparam int WW  = 3 * FW + CDW + BRW + AW;

  typedef enum logic [CDW-1:0] {
    CD_ONE = 2'b00,
    CD_IND = 2'b01,
    CD_SGN = 2'b10,
    CD_ZRO = 2'b11
  } cond_e;

  typedef enum logic [BRW-1:0] {
    BR_JMP  = 2'b00,
    BR_CALL = 2'b01,
    BR_RET  = 2'b10,
    BR_MAP  = 2'b11
  } brk_e;

  typedef struct packed {
    logic [FW-1:0] f1;
    logic [FW-1:0] f2;
    logic [FW-1:0] f3;
    cond_e         cd;
    brk_e          br;
    logic [AW-1:0] ad;
  } uword_t;

  function automatic uword_t mk(input logic [FW-1:0] f1, input logic [FW-1:0] f2,
                                input logic [FW-1:0] f3, input cond_e cd,
                                input brk_e br, input logic [AW-1:0] ad);
    uword_t w;
    w.f1 = f1;
    w.f2 = f2;
    w.f3 = f3;
    w.cd = cd;
    w.br = br;
    w.ad = ad;
    return w;
  endfunction

  // Control store contents; unlisted words are zero
  function automatic uword_t store_word(input logic [AW-1:0] a);
    uword_t w;
    w = '0;
    case (a)
      // opcode 0: accumulate
      7'd0:  w = mk(3'd0, 3'd0, 3'd0, CD_IND, BR_CALL, 7'd67);
      7'd1:  w = mk(3'd0, 3'd4, 3'd0, CD_ONE, BR_JMP,  7'd2);
      7'd2:  w = mk(3'd1, 3'd0, 3'd0, CD_ONE, BR_JMP,  7'd64);
      // opcode 1: branch on negative
      7'd4:  w = mk(3'd0, 3'd0, 3'd0, CD_SGN, BR_JMP,  7'd6);
      7'd5:  w = mk(3'd0, 3'd0, 3'd0, CD_ONE, BR_JMP,  7'd64);
      7'd6:  w = mk(3'd0, 3'd0, 3'd0, CD_IND, BR_CALL, 7'd67);
      7'd7:  w = mk(3'd0, 3'd0, 3'd6, CD_ONE, BR_JMP,  7'd64);
      // opcode 2: store
      7'd8:  w = mk(3'd0, 3'd0, 3'd0, CD_IND, BR_CALL, 7'd67);
      7'd9:  w = mk(3'd0, 3'd5, 3'd0, CD_ONE, BR_JMP,  7'd10);
      7'd10: w = mk(3'd7, 3'd0, 3'd0, CD_ONE, BR_JMP,  7'd64);
      // opcode 3: exchange
      7'd12: w = mk(3'd0, 3'd0, 3'd0, CD_IND, BR_CALL, 7'd67);
      7'd13: w = mk(3'd0, 3'd4, 3'd0, CD_ONE, BR_JMP,  7'd14);
      7'd14: w = mk(3'd4, 3'd5, 3'd0, CD_ONE, BR_JMP,  7'd15);
      7'd15: w = mk(3'd7, 3'd0, 3'd0, CD_ONE, BR_JMP,  7'd64);
      // opcode 4: skip on zero accumulator
      7'd16: w = mk(3'd0, 3'd0, 3'd0, CD_ZRO, BR_JMP,  7'd18);
      7'd17: w = mk(3'd3, 3'd0, 3'd0, CD_ONE, BR_JMP,  7'd64);
      7'd18: w = mk(3'd0, 3'd0, 3'd5, CD_ONE, BR_JMP,  7'd64);
      // fetch routine
      7'd64: w = mk(3'd6, 3'd0, 3'd0, CD_ONE, BR_JMP,  7'd65);
      7'd65: w = mk(3'd0, 3'd4, 3'd5, CD_ONE, BR_JMP,  7'd66);
      7'd66: w = mk(3'd5, 3'd0, 3'd0, CD_ONE, BR_MAP,  7'd0);
      // indirect-address subroutine
      7'd67: w = mk(3'd0, 3'd4, 3'd0, CD_ONE, BR_JMP,  7'd68);
      7'd68: w = mk(3'd5, 3'd0, 3'd0, CD_ONE, BR_RET,  7'd0);
      default: w = '0;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/useq_store.sv
module useq_store
  import useq_pkg::*;
#(
  parameter int ADDR_W = AW
) (
  input  logic [ADDR_W-1:0] addr,
  output uword_t            word
);
  localparam int DEPTH = 2 ** ADDR_W;

  uword_t mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    assign mem[i] = store_word(AW'(i));
  end

  assign word = mem[addr];
endmodule

// File: rtl/useq_fdec.sv
module useq_fdec #(
  parameter int CODE_W = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [CODE_W-1:0]     code,
  output logic [2**CODE_W-1:0]  stb
);
  localparam int LINES = 2 ** CODE_W;

  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign stb[i] = (code == CODE_W'(i));
  end

  // R3: exactly one strobe line per field, every cycle
  assert_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n) $countones(stb) == 1)
    else $error("strobe group not one-hot");
endmodule

// File: rtl/useq_next.sv
module useq_next
  import useq_pkg::*;
#(
  parameter int ADDR_W = AW,
  parameter int OP_W   = 4
) (
  input  uword_t            word,
  input  logic [ADDR_W-1:0] car,
  input  logic [ADDR_W-1:0] sbr,
  input  logic [OP_W-1:0]   dr_opcode,
  input  logic              dr_ind,
  input  logic              ac_sign,
  input  logic              ac_zero,
  output logic              tested,
  output logic              save_ret,
  output logic [ADDR_W-1:0] nxt
);
  localparam int PAD_W = ADDR_W - OP_W - 2;

  logic i1, i0, s1, s0;
  logic [ADDR_W-1:0] map_addr;

  // status bit selection
  always_comb begin
    unique case (word.cd)
      CD_ONE: tested = 1'b1;
      CD_IND: tested = dr_ind;
      CD_SGN: tested = ac_sign;
      CD_ZRO: tested = ac_zero;
      default: tested = 1'b0;
    endcase
  end

  assign i1       = word.br[1];
  assign i0       = word.br[0];
  assign s1       = i1;
  assign s0       = (i0 & i1) | (~i1 & tested);
  assign save_ret = ~i1 & i0 & tested;
  assign map_addr = {{PAD_W{1'b0}}, dr_opcode, 2'b00};

  always_comb begin
    unique case ({s1, s0})
      2'b00:   nxt = car + ADDR_W'(1);
      2'b01:   nxt = word.ad;
      2'b10:   nxt = sbr;
      default: nxt = map_addr;
    endcase
  end
endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
  import useq_pkg::*;
#(
  parameter int ADDR_W     = AW,
  parameter int OP_W       = 4,
  parameter int CODE_W     = FW,
  parameter int FETCH_ADDR = 64
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [OP_W-1:0]       dr_opcode,
  input  logic                  dr_ind,
  input  logic                  ac_sign,
  input  logic                  ac_zero,
  output logic [ADDR_W-1:0]     car,
  output logic [ADDR_W-1:0]     sbr,
  output logic [2**CODE_W-1:0]  f1_stb,
  output logic [2**CODE_W-1:0]  f2_stb,
  output logic [2**CODE_W-1:0]  f3_stb
);
  localparam logic [ADDR_W-1:0] START = ADDR_W'(FETCH_ADDR);

  logic [ADDR_W-1:0] car_q, sbr_q, nxt;
  logic              tested, save_ret;
  uword_t            cur;

  useq_store #(.ADDR_W(ADDR_W)) u_store (
    .addr (car_q),
    .word (cur)
  );

  useq_next #(.ADDR_W(ADDR_W), .OP_W(OP_W)) u_next (
    .word      (cur),
    .car       (car_q),
    .sbr       (sbr_q),
    .dr_opcode (dr_opcode),
    .dr_ind    (dr_ind),
    .ac_sign   (ac_sign),
    .ac_zero   (ac_zero),
    .tested    (tested),
    .save_ret  (save_ret),
    .nxt       (nxt)
  );

  useq_fdec #(.CODE_W(CODE_W)) u_dec1 (.clk(clk), .rst_n(rst_n), .code(cur.f1), .stb(f1_stb));
  useq_fdec #(.CODE_W(CODE_W)) u_dec2 (.clk(clk), .rst_n(rst_n), .code(cur.f2), .stb(f2_stb));
  useq_fdec #(.CODE_W(CODE_W)) u_dec3 (.clk(clk), .rst_n(rst_n), .code(cur.f3), .stb(f3_stb));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      car_q <= START;
      sbr_q <= '0;
    end else begin
      car_q <= nxt;
      if (save_ret) sbr_q <= car_q + ADDR_W'(1);
    end
  end

  assign car = car_q;
  assign sbr = sbr_q;

  assert_jmp_taken_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cur.br == BR_JMP && tested) |=> car_q == $past(cur.ad))
    else $error("taken jump missed target");

  assert_jmp_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cur.br == BR_JMP && !tested) |=> car_q == $past(car_q) + ADDR_W'(1))
    else $error("untaken jump did not step");

  assert_call_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cur.br == BR_CALL && tested) |=> (car_q == $past(cur.ad) && sbr_q == $past(car_q) + ADDR_W'(1)))
    else $error("call did not save return");

  assert_sbr_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(cur.br == BR_CALL && tested) |=> $stable(sbr_q))
    else $error("return register changed without call");

  assert_ret_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cur.br == BR_RET) |=> car_q == $past(sbr_q))
    else $error("return went elsewhere");

  assert_map_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cur.br == BR_MAP) |=> car_q == ADDR_W'({$past(dr_opcode), 2'b00}))
    else $error("map address wrong");
endmodule

// File: tb/sim_useq_ctrl.sv
module sim_useq_ctrl;
  localparam int PERIOD = 10;
  localparam int NROWS  = 48;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] dr_opcode;
  logic       dr_ind, ac_sign, ac_zero;
  logic [6:0] car, sbr;
  logic [7:0] f1_stb, f2_stb, f3_stb;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  useq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .dr_opcode(dr_opcode), .dr_ind(dr_ind),
    .ac_sign(ac_sign), .ac_zero(ac_zero), .car(car), .sbr(sbr),
    .f1_stb(f1_stb), .f2_stb(f2_stb), .f3_stb(f3_stb)
  );

  // {opcode, ind, sign, zero, exp car, exp sbr, f1 code, f2 code, f3 code}
  localparam logic [29:0] TBL [NROWS] = '{
    // opcode 0, direct (R4 fall-through on call, R7 map, R10)
    {4'd0,1'b0,1'b0,1'b1,7'd65,7'd0,3'd0,3'd4,3'd5},
    {4'd0,1'b0,1'b0,1'b1,7'd66,7'd0,3'd5,3'd0,3'd0},
    {4'd0,1'b1,1'b1,1'b1,7'd0, 7'd0,3'd0,3'd0,3'd0},
    {4'd0,1'b0,1'b0,1'b1,7'd1, 7'd0,3'd0,3'd4,3'd0},
    {4'd0,1'b0,1'b0,1'b1,7'd2, 7'd0,3'd1,3'd0,3'd0},
    {4'd0,1'b0,1'b0,1'b1,7'd64,7'd0,3'd6,3'd0,3'd0},
    // opcode 1, negative and indirect (R5 call, R6 return)
    {4'd1,1'b1,1'b1,1'b0,7'd65,7'd0,3'd0,3'd4,3'd5},
    {4'd1,1'b1,1'b1,1'b0,7'd66,7'd0,3'd5,3'd0,3'd0},
    {4'd1,1'b1,1'b1,1'b0,7'd4, 7'd0,3'd0,3'd0,3'd0},
    {4'd1,1'b1,1'b1,1'b0,7'd6, 7'd0,3'd0,3'd0,3'd0},
    {4'd1,1'b1,1'b1,1'b0,7'd67,7'd7,3'd0,3'd4,3'd0},
    {4'd1,1'b1,1'b1,1'b0,7'd68,7'd7,3'd5,3'd0,3'd0},
    {4'd1,1'b0,1'b0,1'b0,7'd7, 7'd7,3'd0,3'd0,3'd6},
    {4'd1,1'b1,1'b1,1'b0,7'd64,7'd7,3'd6,3'd0,3'd0},
    // opcode 1, not negative
    {4'd1,1'b1,1'b0,1'b1,7'd65,7'd7,3'd0,3'd4,3'd5},
    {4'd1,1'b1,1'b0,1'b1,7'd66,7'd7,3'd5,3'd0,3'd0},
    {4'd1,1'b1,1'b0,1'b1,7'd4, 7'd7,3'd0,3'd0,3'd0},
    {4'd1,1'b1,1'b0,1'b1,7'd5, 7'd7,3'd0,3'd0,3'd0},
    {4'd1,1'b1,1'b0,1'b1,7'd64,7'd7,3'd6,3'd0,3'd0},
    // opcode 3, indirect
    {4'd3,1'b1,1'b0,1'b0,7'd65,7'd7, 3'd0,3'd4,3'd5},
    {4'd3,1'b1,1'b0,1'b0,7'd66,7'd7, 3'd5,3'd0,3'd0},
    {4'd3,1'b0,1'b0,1'b1,7'd12,7'd7, 3'd0,3'd0,3'd0},
    {4'd3,1'b1,1'b0,1'b0,7'd67,7'd13,3'd0,3'd4,3'd0},
    {4'd3,1'b1,1'b0,1'b0,7'd68,7'd13,3'd5,3'd0,3'd0},
    {4'd3,1'b1,1'b0,1'b0,7'd13,7'd13,3'd0,3'd4,3'd0},
    {4'd3,1'b1,1'b0,1'b0,7'd14,7'd13,3'd4,3'd5,3'd0},
    {4'd3,1'b1,1'b0,1'b0,7'd15,7'd13,3'd7,3'd0,3'd0},
    {4'd3,1'b1,1'b0,1'b0,7'd64,7'd13,3'd6,3'd0,3'd0},
    // opcode 2, direct: untaken call keeps return register
    {4'd2,1'b0,1'b1,1'b1,7'd65,7'd13,3'd0,3'd4,3'd5},
    {4'd2,1'b0,1'b1,1'b1,7'd66,7'd13,3'd5,3'd0,3'd0},
    {4'd2,1'b0,1'b1,1'b1,7'd8, 7'd13,3'd0,3'd0,3'd0},
    {4'd2,1'b0,1'b1,1'b1,7'd9, 7'd13,3'd0,3'd5,3'd0},
    {4'd2,1'b0,1'b1,1'b1,7'd10,7'd13,3'd7,3'd0,3'd0},
    {4'd2,1'b0,1'b1,1'b1,7'd64,7'd13,3'd6,3'd0,3'd0},
    // opcode 4, accumulator zero (R8 zero select)
    {4'd4,1'b0,1'b0,1'b1,7'd65,7'd13,3'd0,3'd4,3'd5},
    {4'd4,1'b0,1'b0,1'b1,7'd66,7'd13,3'd5,3'd0,3'd0},
    {4'd4,1'b0,1'b0,1'b1,7'd16,7'd13,3'd0,3'd0,3'd0},
    {4'd4,1'b0,1'b0,1'b1,7'd18,7'd13,3'd0,3'd0,3'd5},
    {4'd4,1'b0,1'b0,1'b1,7'd64,7'd13,3'd6,3'd0,3'd0},
    // opcode 4, accumulator nonzero
    {4'd4,1'b1,1'b1,1'b0,7'd65,7'd13,3'd0,3'd4,3'd5},
    {4'd4,1'b1,1'b1,1'b0,7'd66,7'd13,3'd5,3'd0,3'd0},
    {4'd4,1'b1,1'b1,1'b0,7'd16,7'd13,3'd0,3'd0,3'd0},
    {4'd4,1'b1,1'b1,1'b0,7'd17,7'd13,3'd3,3'd0,3'd0},
    {4'd4,1'b1,1'b1,1'b0,7'd64,7'd13,3'd6,3'd0,3'd0},
    // opcode 15 lands on an empty word
    {4'd15,1'b1,1'b1,1'b1,7'd65,7'd13,3'd0,3'd4,3'd5},
    {4'd15,1'b1,1'b1,1'b1,7'd66,7'd13,3'd5,3'd0,3'd0},
    {4'd15,1'b1,1'b1,1'b1,7'd60,7'd13,3'd0,3'd0,3'd0},
    {4'd15,1'b1,1'b1,1'b1,7'd0, 7'd13,3'd0,3'd0,3'd0}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_state(input string tag, input logic [6:0] ecar, input logic [6:0] esbr,
                           input logic [2:0] c1, input logic [2:0] c2, input logic [2:0] c3);
    chk({tag, " R1 R4 R5 R6 R7 R8 address"}, {1'b0, car}, {1'b0, ecar});
    chk({tag, " R5 R6 return register"},     {1'b0, sbr}, {1'b0, esbr});
    chk({tag, " R2 R3 R9 R10 f1 strobes"}, f1_stb, 8'(1) << c1);
    chk({tag, " R2 R3 R9 R10 f2 strobes"}, f2_stb, 8'(1) << c2);
    chk({tag, " R2 R3 R9 R10 f3 strobes"}, f3_stb, 8'(1) << c3);
  endtask

  initial begin
    rst_n = 1'b0; dr_opcode = '0; dr_ind = 1'b0; ac_sign = 1'b0; ac_zero = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state, fetch word decoded (R9)
    chk_state("reset", 7'd64, 7'd0, 3'd6, 3'd0, 3'd0);
    rst_n = 1'b1;
    for (int i = 0; i < NROWS; i++) begin
      dr_opcode = TBL[i][29:26];
      dr_ind    = TBL[i][25];
      ac_sign   = TBL[i][24];
      ac_zero   = TBL[i][23];
      @(posedge clk);
      @(negedge clk);
      chk_state($sformatf("row %0d", i), TBL[i][22:16], TBL[i][15:9],
                TBL[i][8:6], TBL[i][5:3], TBL[i][2:0]);
    end
    // R1: reset in mid-run, after the return register holds 13
    rst_n = 1'b0;
    #1;
    chk("R1 async reset address", {1'b0, car}, 8'd64);
    chk("R1 async reset return register", {1'b0, sbr}, 8'd0);
    @(posedge clk);
    @(negedge clk);
    chk_state("held reset", 7'd64, 7'd0, 3'd6, 3'd0, 3'd0);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk_state("after reset R9", 7'd65, 7'd0, 3'd0, 3'd4, 3'd5);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(PERIOD * 5000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule